// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Front End

This block is the digital side of a four-channel digital-to-analog converter. A host reaches it over a 16-bit parallel bus, a 2-bit channel address, an active-low select strobe and a read/write level. A select falling edge with read/write low stores the bus word in the addressed channel's staging register. The same edge with read/write high drives that staging register back onto the bus. The staging registers do not reach the converters directly. A rising edge on a separate commit pin copies all four staging words into the output code registers in one clock, so every channel changes together.

A clear pin zeroes the output code registers on its rising edge and leaves the staging words in place. A later commit can therefore bring them back. A power-enable pin at low level takes every channel's output enable away. All strobe pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer and then an edge detector. The bidirectional bus pad sits outside the block, which supplies the word to drive and a drive enable.

Plain control pins are used throughout. The bus follows the host's strobes and has no valid/ready handshake, so there is no back-pressure. A transfer is accepted on every qualifying select edge.

Top module: `quad_dac_front`

## Requirements
- R1: The channel address selects channel A for 00, B for 01, C for 10 and D for 11. Channel k's output code is `dac_code_o[16k+15:16k]`.
- R2: A falling edge of `sel_n_i` while `rd_wr_i` is low stores `data_i` in the addressed staging register. No output code changes as a result.
- R3: A rising edge of `commit_i` loads all four output codes from their staging registers in the same clock.
- R4: A write behaves the same whatever the level of `commit_i`. A write made while `commit_i` is held high does not change any output code.
- R5: A falling edge of `sel_n_i` while `rd_wr_i` is high raises `data_oe_o` and presents the addressed staging register on `data_o`. The output code register is not what is returned.
- R6: `data_oe_o` stays high until `sel_n_i` returns high and then drops. While `data_oe_o` is low, `data_o` is zero.
- R7: A rising edge of `clear_i` sets all four output codes to zero and leaves every staging register unchanged.
- R8: After `rst_n` is released, the output codes, the staging registers, `data_oe_o` and `chan_en_o` are all zero. The output codes stay zero until a commit.
- R9: `chan_en_o` is 4'b1111 while `pwr_en_i` is high and 4'b0000 while it is low. Power-down leaves the output codes unchanged.
- R10: When a clear rising edge and a commit rising edge are detected in the same clock, the clear wins and the output codes become zero.
- R11: Every effect of a pin change appears after the third rising clock edge that follows the change. `data_i` and `addr_i` must be held stable across that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sel_n_i | input | 1 | Active-low select strobe |
| rd_wr_i | input | 1 | 1 = readback, 0 = write |
| commit_i | input | 1 | Rising edge commits all staging words |
| clear_i | input | 1 | Rising edge zeroes the output codes |
| pwr_en_i | input | 1 | 1 = channels enabled, 0 = power-down |
| addr_i | input | 2 | Channel address |
| data_i | input | 16 | Bus word from the pad |
| data_o | output | 16 | Readback word to the pad |
| data_oe_o | output | 1 | Pad drive enable |
| dac_code_o | output | 64 | Four 16-bit output codes, channel A in the low lane |
| chan_en_o | output | 4 | Per-channel output enable |

## Verification
Each pin goes through two synchronizer flops and one edge-history flop, and the action is then registered. A write, commit, clear, readback, bus release or power change is therefore due after the third rising edge following the pin change. Every bench task changes pins on a falling clock edge, waits three rising edges and samples at the next falling edge. Address and data stay held until the strobe is released. Retention of the staging words after a clear or a write is checked through readback and through a second commit, never by probing internals.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // bit positions of the strobe pins inside the synchronizer vector
  localparam int PIN_SEL   = 0;
  localparam int PIN_RW    = 1;
  localparam int PIN_LOAD  = 2;
  localparam int PIN_CLR   = 3;
  localparam int PIN_PWR   = 4;
  localparam int NUM_PINS  = 5;
  // idle levels: select released high, all others low
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 5'b00001;
endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
      hist_q <= IDLE;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~hist_q;
  assign fall_o  = ~sync_q & hist_q;

  // R11
  pin_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_q == $past(meta_q));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs #(
  parameter int DW  = 16,
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load,
  input  logic              clear,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NCH*DW-1:0] dac_o
);
  logic [NCH-1:0][DW-1:0] stage_q;
  logic [NCH-1:0][DW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wr_en) begin
      stage_q[wr_addr] <= wr_data;
    end
  end

  // clear has priority over commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clear) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= stage_q;
    end
  end

  assign rd_data = stage_q[rd_addr];
  assign dac_o   = code_q;

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stage_q));
  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> code_q == '0);
  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> code_q == $past(stage_q));
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> $stable(code_q));
endmodule

// File: rtl/qdac_rdport.sv
module qdac_rdport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          sel_level,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_o   <= 1'b0;
      word_q <= '0;
    end else if (rd_stb) begin
      oe_o   <= 1'b1;
      word_q <= rd_word;
    end else if (sel_level) begin
      oe_o   <= 1'b0;
    end
  end

  assign data_o = oe_o ? word_q : '0;

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_level && !rd_stb) |=> !oe_o);
  // R5
  oe_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> oe_o && data_o == $past(rd_word));
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import qdac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              rd_wr_i,
  input  logic              commit_i,
  input  logic              clear_i,
  input  logic              pwr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic [NCH*DW-1:0] dac_code_o,
  output logic [NCH-1:0]    chan_en_o
);
  logic [NUM_PINS-1:0] pins, lvl, rise, fall;
  logic                wr_stb, rd_stb;
  logic [DW-1:0]       rd_word;

  always_comb begin
    pins           = '0;
    pins[PIN_SEL]  = sel_n_i;
    pins[PIN_RW]   = rd_wr_i;
    pins[PIN_LOAD] = commit_i;
    pins[PIN_CLR]  = clear_i;
    pins[PIN_PWR]  = pwr_en_i;
  end

  qdac_pin_sync #(.N(NUM_PINS), .IDLE(PIN_IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (pins),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign wr_stb = fall[PIN_SEL] & ~lvl[PIN_RW];
  assign rd_stb = fall[PIN_SEL] &  lvl[PIN_RW];

  qdac_regs #(.DW(DW), .NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_stb),
    .wr_addr (addr_i),
    .wr_data (data_i),
    .load    (rise[PIN_LOAD]),
    .clear   (rise[PIN_CLR]),
    .rd_addr (addr_i),
    .rd_data (rd_word),
    .dac_o   (dac_code_o)
  );

  qdac_rdport #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .sel_level (lvl[PIN_SEL]),
    .rd_word   (rd_word),
    .data_o    (data_o),
    .oe_o      (data_oe_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_en_o[c] <= 1'b0;
      else        chan_en_o[c] <= lvl[PIN_PWR];
    end
  end

  // R9
  pwr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl[PIN_PWR] |=> chan_en_o == '0);
  // R4
  write_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rise[PIN_LOAD] && !rise[PIN_CLR]) |=> $stable(dac_code_o));
endmodule

// File: tb/quad_dac_front_test.sv
module quad_dac_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_wr = 1'b0, commit = 1'b0, clear = 1'b0, pwr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        oe;
  logic [63:0] codes;
  logic [3:0]  chen;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  quad_dac_front uut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .rd_wr_i(rd_wr),
    .commit_i(commit), .clear_i(clear), .pwr_en_i(pwr), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .dac_code_o(codes),
    .chan_en_o(chen)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [15:0] v);
    addr = ch; din = v; rd_wr = 1'b0; sel_n = 1'b0;
    settle();
    sel_n = 1'b1;
    settle();
  endtask

  task automatic rd(input logic [1:0] ch, input logic [15:0] exp, input string tag);
    addr = ch; rd_wr = 1'b1; sel_n = 1'b0;
    settle();
    chk({tag, " oe"}, {63'd0, oe}, 64'd1);
    chk({tag, " data"}, {48'd0, dout}, {48'd0, exp});
    sel_n = 1'b1;
    settle();
    chk("R6 oe released", {63'd0, oe}, 64'd0);
    chk("R6 data zero", {48'd0, dout}, 64'd0);
    rd_wr = 1'b0;
  endtask

  task automatic pulse_commit();
    commit = 1'b1; settle(); commit = 1'b0; settle();
  endtask

  task automatic t_reset();
    chk("R8 codes", codes, 64'd0);
    chk("R8 oe", {63'd0, oe}, 64'd0);
    chk("R8 chan_en", {60'd0, chen}, 64'd0);
    rd(2'd2, 16'h0000, "R8 staging zero");
  endtask

  task automatic t_write_commit();
    wr(2'd0, 16'hA0A0); wr(2'd1, 16'hB1B1); wr(2'd2, 16'hC2C2); wr(2'd3, 16'hD3D3);
    chk("R2 no code change", codes, 64'd0);
    commit = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 not yet", codes, 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R1 R3 commit lanes", codes, 64'hD3D3_C2C2_B1B1_A0A0);
    commit = 1'b0; settle();
  endtask

  task automatic t_readback();
    wr(2'd1, 16'h1234);
    rd(2'd1, 16'h1234, "R5 staging not code");
    rd(2'd3, 16'hD3D3, "R1 read D");
    chk("R5 code kept", codes, 64'hD3D3_C2C2_B1B1_A0A0);
  endtask

  task automatic t_write_load_high();
    commit = 1'b1; settle();
    pulse_commit();
    commit = 1'b1; settle();
    wr(2'd0, 16'h5555);
    chk("R4 no code change", codes, 64'hD3D3_C2C2_1234_A0A0);
    rd(2'd0, 16'h5555, "R4 write with load high");
    commit = 1'b0; settle();
    pulse_commit();
    chk("R4 commit after", codes, 64'hD3D3_C2C2_1234_5555);
  endtask

  task automatic t_clear();
    clear = 1'b1; settle();
    chk("R7 codes zero", codes, 64'd0);
    clear = 1'b0; settle();
    rd(2'd2, 16'hC2C2, "R7 staging kept");
    pulse_commit();
    chk("R7 recommit", codes, 64'hD3D3_C2C2_1234_5555);
  endtask

  task automatic t_both();
    clear = 1'b1; commit = 1'b1; settle();
    chk("R10 clear wins", codes, 64'd0);
    clear = 1'b0; commit = 1'b0; settle();
  endtask

  task automatic t_power();
    pwr = 1'b1; settle();
    chk("R9 enabled", {60'd0, chen}, 64'hF);
    pulse_commit();
    pwr = 1'b0; settle();
    chk("R9 powered down", {60'd0, chen}, 64'h0);
    chk("R9 codes kept", codes, 64'hD3D3_C2C2_1234_5555);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_write_commit();
        t_readback();
        t_write_load_high();
        t_clear();
        t_both();
        t_power();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule